// File: doc/BRIEF.md
# Write-Completion Polling Controller

This block runs on the host side of a nonvolatile memory after a program or erase command has been sent. It reads one memory location again and again through a simple request/acknowledge read port and decides when the internal write has finished. It supports two status methods. The data-polling method watches bit 7: it reads as the inverse of the written bit while a program runs, and as 0 while an erase runs. The toggle method watches bit 6, which changes on every read while the memory is busy.

A status read can land on the exact moment the write completes, so one good-looking read is not trusted. The controller treats it as tentative and reads the location twice more. It accepts completion only if both of those reads also look complete. Otherwise it goes back to polling. After completion is confirmed, the controller waits a fixed number of cycles so that the whole data bus can settle. It then makes one final read and compares the full word with the expected value (the written data for a program, all ones for an erase).

A limit on the number of status reads guards against a memory that never finishes. The result is reported as a one-cycle done or error pulse, with an error kind that tells a timeout apart from a data miscompare.

Top module: `wpoll_ctrl`

## Requirements
- R1: A `start_i` pulse while idle latches `exp_data_i`, `op_erase_i` (1 = erase, 0 = program) and `mode_toggle_i` (1 = toggle method, 0 = data-polling method), and `busy_o` rises in the next cycle. A `start_i` while `busy_o` is high is ignored and does not change the operation in progress.
- R2: `rd_req_o` stays high until a cycle in which `rd_ack_i` is high. `rd_data_i` is taken in that cycle, and each cycle with both high is exactly one read.
- R3: In data-polling mode, a status read looks complete when bit 7 of `rd_data_i` equals bit 7 of the expected data (program) or equals 1 (erase).
- R4: In toggle mode, a status read looks complete when its bit 6 equals bit 6 of the status read just before it in the same operation. The first status read of an operation never looks complete.
- R5: A status read that looks complete is confirmed only if the next two status reads also look complete. If either of them does not, the controller returns to polling.
- R6: After confirmation, `rd_req_o` stays low for exactly SETTLE_CYC cycles, and then one final read is issued.
- R7: If the final read equals the expected data (program) or all ones (erase), `done_o` pulses. Otherwise `err_o` pulses with `err_kind_o` = 1 (data miscompare).
- R8: At most MAX_POLLS status reads are made. If the MAX_POLLS-th status read does not complete a confirmation, `err_o` pulses with `err_kind_o` = 0 (timeout), and no further reads are made.
- R9: `done_o` and `err_o` are single-cycle pulses in the cycle after the deciding acknowledge, and `busy_o` is low in that same cycle.
- R10: During and after reset, `busy_o`, `rd_req_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a new completion check |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = toggle method, 0 = data-polling method |
| exp_data_i | input | DW | Data that was written (program) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Successful completion pulse |
| err_o | output | 1 | Error pulse |
| err_kind_o | output | 1 | Error kind: 0 = timeout, 1 = data miscompare |

## Verification
The bench plays the memory. It makes tentative good reads that are followed by a busy read, either on the first confirmation read or on the second. A controller that accepts the first good-looking read would finish early and make too few reads. A controller that checks only one confirmation would be fooled by the second-read case. In toggle mode, a repeated bit 6 in the middle of busy reads must not end the poll.

The status-read limit is tested exactly at MAX_POLLS and one read beyond it. An off-by-one limit either times out a write that finished in time or makes an extra read. The bench also measures the settle gap, feeds a final word whose bit 7 matches but whose other bits differ, and sends a second start during a run, which a careless design would latch.

// File: rtl/wpoll_pkg.sv
package wpoll_pkg;

  // Status bit positions; fixed by the memory's status protocol
  localparam int unsigned DP_BIT = 7;
  localparam int unsigned TG_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_CONF1,
    ST_CONF2,
    ST_SETTLE,
    ST_FINAL
  } wp_state_t;

  localparam logic ERR_TIMEOUT = 1'b0;
  localparam logic ERR_DATA    = 1'b1;

  // Bit 7 value that signals completion in data-polling mode
  function automatic logic dp_goal(input logic erase, input logic exp_msb);
    return erase ? 1'b1 : exp_msb;
  endfunction

  // Status read looks complete
  function automatic logic looks_done(input logic toggle_mode, input logic goal,
                                      input logic dp_bit, input logic have_prev,
                                      input logic prev_tg, input logic tg_bit);
    if (toggle_mode) return have_prev && (prev_tg == tg_bit);
    return dp_bit == goal;
  endfunction

endpackage

// File: rtl/wpoll_judge.sv
module wpoll_judge
  import wpoll_pkg::*;
(
  input  logic toggle_mode,
  input  logic goal,
  input  logic dp_bit,
  input  logic have_prev,
  input  logic prev_tg,
  input  logic tg_bit,
  output logic valid
);
  always_comb valid = looks_done(toggle_mode, goal, dp_bit, have_prev, prev_tg, tg_bit);
endmodule

// File: rtl/wpoll_cnt.sv
module wpoll_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/wpoll_seq.sv
module wpoll_seq
  import wpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      rd_ack,
  input  logic      status_valid,
  input  logic      poll_last,
  input  logic      settle_last,
  input  logic      final_match,
  output wp_state_t state,
  output logic      evt_status_ack,
  output logic      evt_confirmed,
  output logic      evt_timeout,
  output logic      evt_final_ack,
  output logic      done_q,
  output logic      err_q,
  output logic      kind_q
);
  wp_state_t nxt;
  logic status_phase;

  always_comb begin
    status_phase   = (state == ST_POLL) || (state == ST_CONF1) || (state == ST_CONF2);
    evt_status_ack = status_phase && rd_ack;
    evt_confirmed  = (state == ST_CONF2) && evt_status_ack && status_valid;
    evt_timeout    = evt_status_ack && poll_last && !evt_confirmed;
    evt_final_ack  = (state == ST_FINAL) && rd_ack;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_POLL;
      ST_POLL:   if (evt_timeout) nxt = ST_IDLE;
                 else if (evt_status_ack && status_valid) nxt = ST_CONF1;
      ST_CONF1:  if (evt_timeout) nxt = ST_IDLE;
                 else if (evt_status_ack) nxt = status_valid ? ST_CONF2 : ST_POLL;
      ST_CONF2:  if (evt_confirmed) nxt = ST_SETTLE;
                 else if (evt_timeout) nxt = ST_IDLE;
                 else if (evt_status_ack) nxt = ST_POLL;
      ST_SETTLE: if (settle_last) nxt = ST_FINAL;
      ST_FINAL:  if (rd_ack) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= ERR_TIMEOUT;
    end else begin
      state  <= nxt;
      done_q <= evt_final_ack && final_match;
      err_q  <= evt_timeout || (evt_final_ack && !final_match);
      if (evt_timeout) kind_q <= ERR_TIMEOUT;
      else if (evt_final_ack && !final_match) kind_q <= ERR_DATA;
    end
  end
endmodule

// File: rtl/wpoll_ctrl.sv
module wpoll_ctrl
  import wpoll_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned MAX_POLLS  = 1024,
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          mode_toggle_i,
  input  logic [DW-1:0] exp_data_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          err_kind_o
);
  function automatic logic [DW-1:0] final_goal(input logic erase, input logic [DW-1:0] d);
    return erase ? {DW{1'b1}} : d;
  endfunction

  logic          erase_q, toggle_q, have_prev_q, prev_tg_q;
  logic [DW-1:0] exp_q, tgt_q;
  wp_state_t     st;
  logic          accept, final_phase, status_valid;
  logic          poll_last, settle_last, final_match;
  logic          evt_status_ack, evt_confirmed, evt_timeout, evt_final_ack;

  assign accept      = start_i && (st == ST_IDLE);
  assign final_phase = (st == ST_FINAL);
  assign tgt_q       = final_goal(erase_q, exp_q);
  assign final_match = (rd_data_i == tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_q     <= 1'b0;
      toggle_q    <= 1'b0;
      exp_q       <= '0;
      have_prev_q <= 1'b0;
      prev_tg_q   <= 1'b0;
    end else if (accept) begin
      erase_q     <= op_erase_i;
      toggle_q    <= mode_toggle_i;
      exp_q       <= exp_data_i;
      have_prev_q <= 1'b0;
    end else if (evt_status_ack) begin
      have_prev_q <= 1'b1;
      prev_tg_q   <= rd_data_i[TG_BIT];
    end
  end

  wpoll_judge u_judge (
    .toggle_mode (toggle_q),
    .goal        (dp_goal(erase_q, exp_q[DP_BIT])),
    .dp_bit      (rd_data_i[DP_BIT]),
    .have_prev   (have_prev_q),
    .prev_tg     (prev_tg_q),
    .tg_bit      (rd_data_i[TG_BIT]),
    .valid       (status_valid)
  );

  wpoll_cnt #(.LIMIT(MAX_POLLS)) u_poll_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (evt_status_ack),
    .last  (poll_last)
  );

  wpoll_cnt #(.LIMIT(SETTLE_CYC)) u_settle_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != ST_SETTLE),
    .inc   (st == ST_SETTLE),
    .last  (settle_last)
  );

  wpoll_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start_i),
    .rd_ack         (rd_ack_i),
    .status_valid   (status_valid),
    .poll_last      (poll_last),
    .settle_last    (settle_last),
    .final_match    (final_match),
    .state          (st),
    .evt_status_ack (evt_status_ack),
    .evt_confirmed  (evt_confirmed),
    .evt_timeout    (evt_timeout),
    .evt_final_ack  (evt_final_ack),
    .done_q         (done_o),
    .err_q          (err_o),
    .kind_q         (err_kind_o)
  );

  assign busy_o   = (st != ST_IDLE);
  assign rd_req_o = (st == ST_POLL) || (st == ST_CONF1) || (st == ST_CONF2) || final_phase;
endmodule

// File: rtl/wpoll_ctrl_chk.sv
module wpoll_ctrl_chk #(
  parameter int unsigned DW         = 8,
  parameter int unsigned MAX_POLLS  = 1024,
  parameter int unsigned SETTLE_CYC = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic          rd_ack_i,
  input logic [DW-1:0] rd_data_i,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] tgt_q,
  input logic          toggle_q,
  input logic          have_prev_q,
  input logic          status_valid,
  input logic          evt_status_ack,
  input logic          evt_confirmed,
  input logic          evt_timeout,
  input logic          final_phase
);
  localparam int unsigned SW = $clog2(MAX_POLLS + 1) + 1;
  localparam int unsigned GW = $clog2(SETTLE_CYC + 1) + 1;

  logic [SW-1:0] sc;
  logic [1:0]    run;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc  <= '0;
      run <= '0;
      gap <= '0;
    end else begin
      if (start_i && !busy_o) begin
        sc  <= '0;
        run <= '0;
      end else if (evt_status_ack) begin
        sc  <= sc + 1'b1;
        run <= status_valid ? ((run == 2'd3) ? run : run + 1'b1) : 2'd0;
      end
      if (!busy_o || rd_req_o) gap <= '0;
      else if (gap != {GW{1'b1}}) gap <= gap + 1'b1;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tgt_q));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o);
  a_r4_first_read_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_status_ack && toggle_q && !have_prev_q) |-> !status_valid);
  a_r5_two_confirms: assert property (@(posedge clk) disable iff (!rst_n)
    evt_confirmed |-> (run == 2'd2));
  a_r8_limit: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |-> (sc == SW'(MAX_POLLS - 1)));
  a_r6_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_req_o) && final_phase) |-> (gap == GW'(SETTLE_CYC)));
  a_r7_done_data: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rd_ack_i) && ($past(rd_data_i) == $past(tgt_q))));
endmodule

bind wpoll_ctrl wpoll_ctrl_chk #(
  .DW(DW), .MAX_POLLS(MAX_POLLS), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .rd_req_o       (rd_req_o),
  .rd_ack_i       (rd_ack_i),
  .rd_data_i      (rd_data_i),
  .done_o         (done_o),
  .err_o          (err_o),
  .tgt_q          (tgt_q),
  .toggle_q       (toggle_q),
  .have_prev_q    (have_prev_q),
  .status_valid   (status_valid),
  .evt_status_ack (evt_status_ack),
  .evt_confirmed  (evt_confirmed),
  .evt_timeout    (evt_timeout),
  .final_phase    (final_phase)
);

// File: tb/sim_wpoll_ctrl.sv
`timescale 1ns/1ps
module sim_wpoll_ctrl;
  localparam int MAXP = 16;
  localparam int SETL = 3;

  typedef struct packed {
    logic       erase;
    logic       tog;
    logic [7:0] expd;
    logic [7:0] fin;
    logic [7:0] busy;
    logic [7:0] g;
    logic [1:0] glen;
    logic [1:0] lat;
  } vec_t;

  // erase, toggle, expected, final word, busy reads, glitch at, glitch length, latency
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 8'hA5, 8'hA5, 8'd3,  8'd0, 2'd0, 2'd0},
    '{1'b0, 1'b0, 8'h3C, 8'h3C, 8'd5,  8'd1, 2'd1, 2'd1},
    '{1'b0, 1'b0, 8'h5A, 8'h5A, 8'd6,  8'd1, 2'd2, 2'd2},
    '{1'b1, 1'b0, 8'h00, 8'hFF, 8'd4,  8'd0, 2'd0, 2'd1},
    '{1'b1, 1'b0, 8'h00, 8'hF7, 8'd2,  8'd0, 2'd0, 2'd0},
    '{1'b0, 1'b1, 8'h96, 8'h96, 8'd4,  8'd0, 2'd0, 2'd0},
    '{1'b1, 1'b1, 8'h00, 8'hFF, 8'd6,  8'd2, 2'd1, 2'd1},
    '{1'b0, 1'b0, 8'h81, 8'h80, 8'd0,  8'd0, 2'd0, 2'd1},
    '{1'b0, 1'b0, 8'hC3, 8'hC3, 8'd13, 8'd0, 2'd0, 2'd0},
    '{1'b0, 1'b0, 8'hC3, 8'hC3, 8'd14, 8'd0, 2'd0, 2'd0},
    '{1'b0, 1'b1, 8'h69, 8'h69, 8'd12, 8'd0, 2'd0, 2'd1},
    '{1'b0, 1'b1, 8'h69, 8'h69, 8'd13, 8'd0, 2'd0, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, op_erase_i = 1'b0, mode_toggle_i = 1'b0;
  logic [7:0] exp_data_i = 8'h00;
  logic rd_ack_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic rd_req_o, busy_o, done_o, err_o, err_kind_o;

  int nchk = 0, nfail = 0;
  int k = 0, wcnt = 0, gapcnt = 0, last_gap = 0;
  vec_t cur;

  always #5 clk = ~clk;

  wpoll_ctrl #(.DW(8), .MAX_POLLS(MAXP), .SETTLE_CYC(SETL)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .mode_toggle_i(mode_toggle_i), .exp_data_i(exp_data_i), .rd_req_o(rd_req_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .err_kind_o(err_kind_o)
  );

  // Memory model: word returned for read number n of the current operation
  function automatic logic [7:0] resp(input int n);
    int busy_n, gi, kk;
    logic t7, b6;
    busy_n = int'(cur.busy);
    gi = int'(cur.g);
    t7 = cur.erase ? 1'b1 : cur.expd[7];
    if (n >= busy_n) return cur.fin;
    if (!cur.tog) begin
      if (cur.glen != 0 && n >= gi && n < gi + int'(cur.glen)) return {t7, cur.fin[6:0]};
      return {~t7, cur.fin[6:0]};
    end
    kk = (cur.glen != 0 && n == gi) ? n - 1 : n;
    b6 = cur.fin[6] ^ (((busy_n - 1 - kk) % 2) == 0);
    return {cur.fin[7], b6, cur.fin[5:0]};
  endfunction

  always @(negedge clk) begin
    if (rd_ack_i) begin
      k = k + 1;
      rd_ack_i = 1'b0;
      wcnt = 0;
    end
    if (rd_req_o) begin
      if (wcnt >= int'(cur.lat)) begin
        rd_ack_i = 1'b1;
        rd_data_i = resp(k);
      end else begin
        wcnt = wcnt + 1;
      end
    end
    if (busy_o && !rd_req_o) gapcnt = gapcnt + 1;
    else if (rd_req_o && gapcnt != 0) begin
      last_gap = gapcnt;
      gapcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke_start, output int reads);
    int n, status_n, exp_reads, k_end;
    bit seen, got_done, got_err, got_kind, want_to, want_ok;
    string otag;
    cur = v;
    k = 0;
    last_gap = 0;
    @(negedge clk);
    start_i = 1'b1; op_erase_i = v.erase; mode_toggle_i = v.tog; exp_data_i = v.expd;
    @(negedge clk);
    start_i = 1'b0;
    n = 0; seen = 0;
    while (!seen && n < 5000) begin
      if (poke_start && n == 4) begin
        start_i = 1'b1; op_erase_i = 1'b1; mode_toggle_i = 1'b1; exp_data_i = 8'h00;
      end else start_i = 1'b0;
      @(negedge clk); #1;
      if (done_o || err_o) seen = 1;
      n++;
    end
    start_i = 1'b0;
    got_done = done_o; got_err = err_o; got_kind = err_kind_o;
    reads = k;
    // Expectation from the requirements
    status_n = int'(v.busy) + (v.tog ? 4 : 3);
    want_to = (status_n > MAXP);
    want_ok = !want_to && (v.fin == (v.erase ? 8'hFF : v.expd));
    exp_reads = want_to ? MAXP : status_n + 1;
    otag = want_to ? "R8" : (!want_ok ? "R7" : (v.glen != 0 ? "R5" : (v.tog ? "R4" : "R3")));
    chk(got_done == want_ok, {otag, " done"}, got_done, want_ok);
    chk(got_err == !want_ok, {otag, " err"}, got_err, !want_ok);
    if (!want_ok) chk(got_kind == !want_to, {otag, " kind"}, got_kind, !want_to);
    chk(reads == exp_reads, "R2 read count", reads, exp_reads);
    chk(busy_o == 1'b0, "R9 busy low with pulse", busy_o, 0);
    if (!want_to) chk(last_gap == SETL, "R6 settle gap", last_gap, SETL);
    @(negedge clk); #1;
    chk(!done_o && !err_o, "R9 single-cycle pulse", done_o | err_o, 0);
    k_end = k;
    repeat (4) @(negedge clk);
    #1;
    chk(k == k_end && !rd_req_o, want_to ? "R8 no reads after end" : "R9 no reads after end",
        k, k_end);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int r;
    cur = VECS[0];
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !rd_req_o && !done_o && !err_o, "R10 in reset",
        busy_o + rd_req_o + done_o + err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!busy_o && !rd_req_o && !done_o && !err_o, "R10 after reset",
        busy_o + rd_req_o + done_o + err_o, 0);

    foreach (VECS[i]) run_vec(VECS[i], 1'b0, r);

    // R1: start during busy is ignored (program, data-polling, 8 busy reads)
    run_vec('{1'b0, 1'b0, 8'hA5, 8'hA5, 8'd8, 8'd0, 2'd0, 2'd1}, 1'b1, r);
    chk(r == 12, "R1 second start ignored", r, 12);

    // R1: busy rises one cycle after start
    @(negedge clk);
    cur = '{1'b0, 1'b0, 8'h11, 8'h11, 8'd1, 8'd0, 2'd0, 2'd0};
    k = 0;
    start_i = 1'b1; op_erase_i = 1'b0; mode_toggle_i = 1'b0; exp_data_i = 8'h11;
    #1;
    chk(busy_o == 1'b0, "R1 busy not before edge", busy_o, 0);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule